// File: doc/BRIEF.md
# Sliced-Data Interrupt and Caption Readback Controller

This block turns detection strobes from a vertical-blanking data slicer into host-visible interrupt state. Four services feed it: closed caption, copy-generation/widescreen change, guide/programme/time change and timecode. Each service has a sticky status bit and a mask bit. A single active-high interrupt line is raised while any unmasked status bit is set.

Caption payloads go into a readback buffer. Once the buffer holds data it is frozen until the host writes a separate data-consumed bit. Clearing the caption status bit only withdraws the interrupt; it does not release the buffer. A host therefore clears the interrupt, reads the payload, and then signals consumption. After that, the next caption strobe may refill the buffer.

The host port is a single-cycle write strobe with a combinational read of the addressed register.

Top module: `vbi_irq_ctrl`

## Requirements
- R1: After reset, the mask register, every status bit, the caption-available flag, the buffer contents and `irq_o` are all 0.
- R2: Address 0 is the read/write mask register and address 1 is the read-only status register. Source index i of `evt_i` maps to bit 2*i (caption bit 0, copy/widescreen bit 2, guide bit 4, timecode bit 6). Odd bits read 0, and writes to address 1 change nothing.
- R3: A source's status bit is set one clock after its event, whether or not the source is masked. It then holds until it is cleared.
- R4: Writing 1 to a bit of the clear register (address 2) clears the matching status bit. Writing 0 has no effect. An event on the same source in the same cycle wins, so the bit stays set.
- R5: A write that takes a mask bit from 0 to 1 clears that source's status bit, unless an event for that source arrives in the same cycle.
- R6: `irq_o` is a register that equals the OR of (status AND mask) from the previous cycle, active high.
- R7: A caption event while the buffer is free loads `cap_data_i`, sets the caption-available flag and sets caption status.
- R8: A caption event while the buffer is frozen leaves the data, the available flag and the caption status unchanged.
- R9: Clearing caption status drops the interrupt but leaves the available flag and the buffer data unchanged.
- R10: Writing 1 to bit 0 of address 3 clears the available flag and keeps the data. A caption event in that same cycle is not loaded, but the next one is.
- R11: Reads of address 2 and address 3 return 0. Address 4 bit 0 is the available flag. Addresses 5 upward return the caption bytes, least significant byte first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 4 | Slicer event strobes, index 0 caption, 1 copy/widescreen, 2 guide/time, 3 timecode |
| cap_data_i | input | CAP_W | Caption payload qualified by evt_i[0] |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
A vector table sweeps combinations of mask value, event set and clear pattern. This separates recording (masked sources still latch status) from reporting (only unmasked bits reach the interrupt), and confirms each source lands on its own bit position. Directed sequences then cover the collisions: clear against event, unmask against event, and consume against caption event. They also check the one-cycle interrupt lag. A caption series of load, freeze, status clear, release and reload, using distinct payloads, shows that interrupt clearing and buffer release act on separate state.

// File: rtl/vbi_irq_pkg.sv
// Shared constants for the sliced-data interrupt controller.
// Assumes an 8-bit register file with a 4-bit address space.
package vbi_irq_pkg;
    localparam int NSRC   = 4;
    localparam int REG_W  = 8;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_MASK  = 4'd0;
    localparam logic [ADDR_W-1:0] A_STAT  = 4'd1;
    localparam logic [ADDR_W-1:0] A_CLR   = 4'd2;
    localparam logic [ADDR_W-1:0] A_DONE  = 4'd3;
    localparam logic [ADDR_W-1:0] A_CAPST = 4'd4;
    localparam logic [ADDR_W-1:0] A_CAPD  = 4'd5;

    // Register bit position used by a source index.
    function automatic int src_bit(input int idx);
        return 2 * idx;
    endfunction
endpackage

// File: rtl/vbi_status_cell.sv
// One sticky status bit.
// Priority: event > (clear | unmask).
// Assumes clr_i and unmask_i are single-cycle pulses.
module vbi_status_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic clr_i,
    input  logic unmask_i,
    output logic stat_o
);
    logic stat_q;

    // Set on event, drop on clear or fresh unmask.
    always_ff @(posedge clk) begin
        if (!rst_n)                 stat_q <= 1'b0;
        else if (evt_i)             stat_q <= 1'b1;
        else if (clr_i || unmask_i) stat_q <= 1'b0;
    end

    assign stat_o = stat_q;

    assert_evt_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i |=> stat_q);
    assert_clr_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !evt_i) |=> !stat_q);
    assert_unmask_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (unmask_i && !evt_i) |=> !stat_q);
endmodule

// File: rtl/vbi_cap_buf.sv
// Caption readback buffer.
// It loads on a caption event only while free, then freezes until consume_i.
// Assumes consume_i is a single-cycle pulse.
module vbi_cap_buf #(
    parameter int CAP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_evt_i,
    input  logic [CAP_W-1:0] cap_data_i,
    input  logic             consume_i,
    output logic             load_o,
    output logic             avail_o,
    output logic [CAP_W-1:0] data_o
);
    logic             avail_q;
    logic [CAP_W-1:0] data_q;
    logic             load;

    assign load = cap_evt_i && !avail_q;

    // Available flag: set on load, cleared by the host's consume write.
    always_ff @(posedge clk) begin
        if (!rst_n)         avail_q <= 1'b0;
        else if (load)      avail_q <= 1'b1;
        else if (consume_i) avail_q <= 1'b0;
    end

    // Payload register: written only on an accepted load.
    always_ff @(posedge clk) begin
        if (!rst_n)    data_q <= '0;
        else if (load) data_q <= cap_data_i;
    end

    assign load_o  = load;
    assign avail_o = avail_q;
    assign data_o  = data_q;

    assert_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (avail_q && !consume_i) |=> (avail_q && $stable(data_q)));
    assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_evt_i && !avail_q) |=> (avail_q && data_q == $past(cap_data_i)));
    assert_consume_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (consume_i && avail_q) |=> (!avail_q && $stable(data_q)));
endmodule

// File: rtl/vbi_reg_if.sv
// Host register decode: mask storage, clear/unmask/consume pulses, read mux.
// Assumes single-cycle write strobes and a combinational read.
module vbi_reg_if
    import vbi_irq_pkg::*;
#(
    parameter int CAP_BYTES = 2,
    localparam int CAP_W = 8 * CAP_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    input  logic [NSRC-1:0]   stat_i,
    input  logic              avail_i,
    input  logic [CAP_W-1:0]  cap_i,
    output logic [NSRC-1:0]   mask_o,
    output logic [NSRC-1:0]   clr_o,
    output logic [NSRC-1:0]   unmask_o,
    output logic              consume_o,
    output logic [REG_W-1:0]  rdata_o
);
    logic [NSRC-1:0] mask_q;
    logic            wr_mask, wr_clr;
    logic            unused_odd;

    assign wr_mask    = wr_i && (addr_i == A_MASK);
    assign wr_clr     = wr_i && (addr_i == A_CLR);
    assign consume_o  = wr_i && (addr_i == A_DONE) && wdata_i[0];
    assign unused_odd = ^{wdata_i[7], wdata_i[5], wdata_i[3], wdata_i[1]};

    // Per-source pulses taken from the even data bits.
    always_comb begin
        for (int i = 0; i < NSRC; i++) begin
            clr_o[i]    = wr_clr  && wdata_i[src_bit(i)];
            unmask_o[i] = wr_mask && wdata_i[src_bit(i)] && !mask_q[i];
        end
    end

    // Mask register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else if (wr_mask) begin
            for (int i = 0; i < NSRC; i++) mask_q[i] <= wdata_i[src_bit(i)];
        end
    end

    assign mask_o = mask_q;

    // Read mux; write-only addresses and unused bits return 0.
    always_comb begin
        rdata_o = '0;
        if (addr_i == A_MASK) begin
            for (int i = 0; i < NSRC; i++) rdata_o[src_bit(i)] = mask_q[i];
        end else if (addr_i == A_STAT) begin
            for (int i = 0; i < NSRC; i++) rdata_o[src_bit(i)] = stat_i[i];
        end else if (addr_i == A_CAPST) begin
            rdata_o[0] = avail_i;
        end else begin
            for (int b = 0; b < CAP_BYTES; b++) begin
                if (int'(addr_i) == int'(A_CAPD) + b) rdata_o = cap_i[8*b +: 8];
            end
        end
    end

    assert_mask_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_mask |=> $stable(mask_q));
    assert_wo_reads_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == A_CLR || addr_i == A_DONE) |-> (rdata_o == '0));
endmodule

// File: rtl/vbi_irq_ctrl.sv
// Top level: four status cells, the caption buffer, the register decode,
// and a registered interrupt line.
// Assumes event strobes are synchronous to clk.
module vbi_irq_ctrl
    import vbi_irq_pkg::*;
#(
    parameter int CAP_BYTES = 2,
    localparam int CAP_W = 8 * CAP_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   evt_i,
    input  logic [CAP_W-1:0]  cap_data_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    output logic              irq_o
);
    logic [NSRC-1:0]  stat, mask, clr, unmask, src_evt;
    logic             consume, cap_load, cap_avail;
    logic [CAP_W-1:0] cap_q;
    logic             irq_q;

    vbi_cap_buf #(.CAP_W(CAP_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .cap_evt_i(evt_i[0]), .cap_data_i(cap_data_i),
        .consume_i(consume), .load_o(cap_load), .avail_o(cap_avail), .data_o(cap_q)
    );

    // The caption source reports only accepted loads.
    assign src_evt = {evt_i[NSRC-1:1], cap_load};

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        vbi_status_cell u_cell (
            .clk(clk), .rst_n(rst_n), .evt_i(src_evt[g]), .clr_i(clr[g]),
            .unmask_i(unmask[g]), .stat_o(stat[g])
        );
    end

    vbi_reg_if #(.CAP_BYTES(CAP_BYTES)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
        .wdata_i(reg_wdata_i), .stat_i(stat), .avail_i(cap_avail), .cap_i(cap_q),
        .mask_o(mask), .clr_o(clr), .unmask_o(unmask), .consume_o(consume),
        .rdata_o(reg_rdata_o)
    );

    // Registered interrupt request.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(stat & mask);
    end

    assign irq_o = irq_q;

    assert_irq_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(stat & mask)) |=> !irq_o);
    assert_irq_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(stat & mask)) |=> irq_o);
endmodule

// File: tb/vbi_irq_ctrl_tb.sv
module vbi_irq_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  evt = '0;
    logic [15:0] cap = '0;
    logic        wr = 1'b0;
    logic [3:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        irq;
    int          n_run = 0;
    int          n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vbi_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .cap_data_i(cap),
        .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq)
    );

    typedef struct packed {
        logic [7:0] mask;
        logic [3:0] ev;
        logic [7:0] clr;
        logic [7:0] stat;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{8'h00, 4'b1111, 8'h00, 8'h55},
        '{8'h01, 4'b0001, 8'h00, 8'h01},
        '{8'h04, 4'b0010, 8'h00, 8'h04},
        '{8'h10, 4'b0100, 8'h00, 8'h10},
        '{8'h40, 4'b1000, 8'h00, 8'h40},
        '{8'h55, 4'b1111, 8'h14, 8'h41},
        '{8'h55, 4'b0110, 8'h14, 8'h00},
        '{8'h14, 4'b1001, 8'h00, 8'h41},
        '{8'h00, 4'b0000, 8'h00, 8'h00},
        '{8'h41, 4'b1010, 8'h01, 8'h44}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One-cycle drive of events and a write.
    task automatic cyc(input logic [3:0] e, input logic w, input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        evt = e; wr = w; addr = a; wdata = d;
        @(negedge clk);
        evt = '0; wr = 1'b0;
    endtask

    task automatic peek(input logic [3:0] a, output logic [7:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        peek(4'd0, v); chk("R1 mask", v, 8'h00);
        peek(4'd1, v); chk("R1 status", v, 8'h00);
        peek(4'd4, v); chk("R1 avail", v, 8'h00);
        peek(4'd5, v); chk("R1 data", v, 8'h00);
        chk("R1 irq", irq, 1'b0);

        // Vector table: R2 R3 R4 R6
        foreach (VECS[k]) begin
            cyc(4'b0, 1'b1, 4'd2, 8'h55);
            cyc(4'b0, 1'b1, 4'd3, 8'h01);
            cyc(4'b0, 1'b1, 4'd0, VECS[k].mask);
            cap = 16'h1000 + 16'(k);
            cyc(VECS[k].ev, 1'b0, 4'd0, 8'h00);
            if (VECS[k].clr != 0) cyc(4'b0, 1'b1, 4'd2, VECS[k].clr);
            @(negedge clk);
            peek(4'd1, v); chk("R3 vector status", v, VECS[k].stat);
            chk("R6 vector irq", irq, |(VECS[k].stat & VECS[k].mask));
        end

        // R2: mask odd bits read 0; status is read-only
        cyc(4'b0, 1'b1, 4'd0, 8'hFF);
        peek(4'd0, v); chk("R2 mask readback", v, 8'h55);
        cyc(4'b0, 1'b1, 4'd0, 8'h00);
        cyc(4'b0, 1'b1, 4'd2, 8'h55);
        cyc(4'b0010, 1'b0, 4'd0, 8'h00);
        cyc(4'b0, 1'b1, 4'd1, 8'h00);
        peek(4'd1, v); chk("R2 status read-only", v, 8'h04);
        // R4: writing 0 to clear has no effect
        cyc(4'b0, 1'b1, 4'd2, 8'h00);
        peek(4'd1, v); chk("R4 zero write", v, 8'h04);
        // R4: event wins over clear in the same cycle
        cyc(4'b0010, 1'b1, 4'd2, 8'h04);
        peek(4'd1, v); chk("R4 event beats clear", v, 8'h04);

        // R5: unmask clears status
        cyc(4'b0, 1'b1, 4'd0, 8'h04);
        peek(4'd1, v); chk("R5 unmask clears", v, 8'h00);
        @(negedge clk); chk("R5 irq stays low", irq, 1'b0);
        // R5: event in the unmask cycle survives
        cyc(4'b0, 1'b1, 4'd0, 8'h00);
        cyc(4'b0100, 1'b1, 4'd0, 8'h10);
        peek(4'd1, v); chk("R5 event beats unmask", v, 8'h10);

        // R6: one-cycle latency
        cyc(4'b0, 1'b1, 4'd2, 8'h55);
        cyc(4'b0, 1'b1, 4'd0, 8'h40);
        @(negedge clk); chk("R6 irq idle", irq, 1'b0);
        cyc(4'b1000, 1'b0, 4'd0, 8'h00);
        chk("R6 irq not yet", irq, 1'b0);
        @(negedge clk); chk("R6 irq raised", irq, 1'b1);
        cyc(4'b0, 1'b1, 4'd2, 8'h40);
        @(negedge clk); chk("R6 irq dropped", irq, 1'b0);

        // R7: caption load
        cyc(4'b0, 1'b1, 4'd3, 8'h01);
        cyc(4'b0, 1'b1, 4'd0, 8'h01);
        cap = 16'hA1B2;
        cyc(4'b0001, 1'b0, 4'd0, 8'h00);
        peek(4'd4, v); chk("R7 avail", v, 8'h01);
        peek(4'd5, v); chk("R7 data low", v, 8'hB2);
        peek(4'd6, v); chk("R7 data high", v, 8'hA1);
        peek(4'd1, v); chk("R7 status", v, 8'h01);
        @(negedge clk); chk("R7 irq", irq, 1'b1);

        // R9: status clear keeps the buffer
        cyc(4'b0, 1'b1, 4'd2, 8'h01);
        @(negedge clk); chk("R9 irq low", irq, 1'b0);
        peek(4'd4, v); chk("R9 avail kept", v, 8'h01);
        peek(4'd5, v); chk("R9 data kept", v, 8'hB2);

        // R8: frozen buffer ignores a caption event
        cap = 16'h3344;
        cyc(4'b0001, 1'b0, 4'd0, 8'h00);
        peek(4'd6, v); chk("R8 data frozen", v, 8'hA1);
        peek(4'd1, v); chk("R8 status unchanged", v, 8'h00);
        peek(4'd4, v); chk("R8 avail", v, 8'h01);

        // R10: consume with a same-cycle event does not load
        cap = 16'h5566;
        cyc(4'b0001, 1'b1, 4'd3, 8'h01);
        peek(4'd4, v); chk("R10 released", v, 8'h00);
        peek(4'd5, v); chk("R10 data kept", v, 8'hB2);
        cap = 16'h7788;
        cyc(4'b0001, 1'b0, 4'd0, 8'h00);
        peek(4'd5, v); chk("R10 reload low", v, 8'h88);
        peek(4'd6, v); chk("R10 reload high", v, 8'h77);

        // R11: write-only addresses read 0
        peek(4'd2, v); chk("R11 clear reads 0", v, 8'h00);
        peek(4'd3, v); chk("R11 consume reads 0", v, 8'h00);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule